// File: doc/BRIEF.md
# Subtractive-Decode Bus Responder

This block sits on a 32-bit PCI bus on behalf of a bridge to an older, narrower peripheral bus. Instead of matching an address window, it claims a transaction by elimination: it captures the address and command when the initiator starts the cycle. It then watches the DEVSEL# line that the other agents drive. If no one has answered by the last slot a positive-decode target may use, and the address and command lie in the legacy space, it asserts DEVSEL# itself. Its answer comes after every positive decoder has had its chance and before the initiator gives up with a master abort.

The slot is chosen by the `fast_all_i` input. With it low, other agents may answer as late as the slow slot, and this block drives DEVSEL# so that it is sampled at clock 5. With it high, every other agent is known to answer at the medium slot or earlier, and the claim moves one clock forward to clock 4. When the block claims, it raises `claim_o` for one cycle along with the captured address and command. Carrying the cycle onward to the legacy bus and handling the data phases belong to other blocks.

The control is one state machine with five states. IDLE waits for FRAME# low. Entering a cycle, it goes to WAIT for an eligible command and address, or to PASS otherwise. WAIT counts the sampling edges: a DEVSEL# from another agent moves it to PASS, and reaching the last look edge with none moves it to CLAIM. CLAIM holds DEVSEL# low until FRAME# is sampled high, then goes to TURNOFF. TURNOFF drives DEVSEL# high for one cycle and returns to IDLE. PASS waits for FRAME# high and returns to IDLE.

Top module: `subtractive_responder`

## Requirements
- R1: The address and command are captured on the clock edge at which FRAME# is first sampled low from IDLE (clock 1). `claim_addr_o` and `claim_cmd_o` show those captured values even though AD and C/BE# change afterwards.
- R2: Memory commands are eligible only when address bits 31:24 are all zero. The memory command codes, as C/BE#[3:0] values, are 0110, 0111, 1100, 1110 and 1111.
- R3: I/O commands are eligible only when address bits 31:16 are all zero. The I/O command codes are 0010 and 0011.
- R4: Every other command code is never claimed. This includes configuration (1010, 1011), dual-address (1101), interrupt acknowledge (0000) and special cycle (0001).
- R5: With `fast_all_i` low, if DEVSEL# from other agents is high at clocks 2, 3 and 4, `devsel_n_o` goes low with `devsel_oe_o` high right after clock 4, so it is sampled at clock 5. `claim_o` is high for exactly that one cycle.
- R6: With `fast_all_i` high, the claim happens after clock 3 when other agents' DEVSEL# was high at clocks 2 and 3, so it is sampled at clock 4.
- R7: If another agent's DEVSEL# is sampled low at any look edge before the claim, including the last look edge itself, the block does not claim.
- R8: A cycle this block does not claim is never driven: `devsel_oe_o` stays low, so the initiator's master abort at clock 6 takes effect.
- R9: While claimed, the first edge at which FRAME# is sampled high leads to one cycle with `devsel_oe_o` high and `devsel_n_o` high. After that cycle `devsel_oe_o` is low.
- R10: During and right after reset, `devsel_oe_o` and `claim_o` are low and `devsel_n_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| fast_all_i | input | 1 | All other agents answer at medium DEVSEL or faster |
| frame_n_i | input | 1 | FRAME#, active low |
| ad_i | input | 32 | Address/data bus |
| cbe_n_i | input | 4 | Command / byte enables |
| devsel_n_i | input | 1 | DEVSEL# as driven by the other agents, active low |
| devsel_n_o | output | 1 | DEVSEL# value driven by this block |
| devsel_oe_o | output | 1 | Output enable for `devsel_n_o` |
| claim_o | output | 1 | One-cycle pulse when the block claims a cycle |
| claim_addr_o | output | 32 | Captured address |
| claim_cmd_o | output | 4 | Captured command |

## Verification
The bench runs every one of the 16 command codes against addresses placed just inside and just outside the 16-bit and 24-bit limits. It does this in both slot modes, with other agents answering at each legal slot or not at all. A block that claimed one clock early would collide with a slow positive decoder. One that checked the range on the wrong width would steal cycles meant for memory above 16 MB. One that missed a DEVSEL# seen on the last look edge would drive against another target. The bench also changes AD and C/BE# right after clock 1, so a block that captured late would report the wrong address. It checks that DEVSEL# is driven high for exactly one cycle before release.

// File: rtl/sdr_pkg.sv
package sdr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_CLAIM,
        ST_TURNOFF,
        ST_PASS
    } sdr_state_e;

    localparam logic [3:0] CMD_IO_RD   = 4'b0010;
    localparam logic [3:0] CMD_IO_WR   = 4'b0011;
    localparam logic [3:0] CMD_MEM_RD  = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR  = 4'b0111;
    localparam logic [3:0] CMD_MEM_RDM = 4'b1100;
    localparam logic [3:0] CMD_MEM_RDL = 4'b1110;
    localparam logic [3:0] CMD_MEM_WRI = 4'b1111;

    function automatic logic is_mem_cmd(input logic [3:0] cmd);
        return (cmd == CMD_MEM_RD)  || (cmd == CMD_MEM_WR)  ||
               (cmd == CMD_MEM_RDM) || (cmd == CMD_MEM_RDL) ||
               (cmd == CMD_MEM_WRI);
    endfunction

    function automatic logic is_io_cmd(input logic [3:0] cmd);
        return (cmd == CMD_IO_RD) || (cmd == CMD_IO_WR);
    endfunction

endpackage

// File: rtl/sdr_range_filter.sv
module sdr_range_filter
    import sdr_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int MEM_AW = 24,
    parameter int IO_AW  = 16
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [3:0]        cmd_i,
    output logic              eligible_o
);

    logic mem_fits;
    logic io_fits;

    generate
        if (MEM_AW >= ADDR_W) begin : g_mem_full
            assign mem_fits = 1'b1;
        end else begin : g_mem_cut
            assign mem_fits = (addr_i[ADDR_W-1:MEM_AW] == '0);
        end
        if (IO_AW >= ADDR_W) begin : g_io_full
            assign io_fits = 1'b1;
        end else begin : g_io_cut
            assign io_fits = (addr_i[ADDR_W-1:IO_AW] == '0);
        end
    endgenerate

    always_comb begin
        eligible_o = (is_mem_cmd(cmd_i) && mem_fits) ||
                     (is_io_cmd(cmd_i) && io_fits);
    end

endmodule

// File: rtl/sdr_claim_fsm.sv
module sdr_claim_fsm
    import sdr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int SLOT_W    = 3,
    parameter int FAST_LAST = 3,
    parameter int SLOW_LAST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_all_i,
    input  logic              frame_n_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic [3:0]        cbe_n_i,
    input  logic              devsel_n_i,
    input  logic              eligible_i,
    output logic              devsel_n_o,
    output logic              devsel_oe_o,
    output logic              claim_o,
    output logic [ADDR_W-1:0] claim_addr_o,
    output logic [3:0]        claim_cmd_o
);

    localparam logic [SLOT_W-1:0] FAST_EDGE = SLOT_W'(FAST_LAST);
    localparam logic [SLOT_W-1:0] SLOW_EDGE = SLOT_W'(SLOW_LAST);

    sdr_state_e        state_q, state_d;
    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [SLOT_W-1:0] this_edge;
    logic [SLOT_W-1:0] last_look;
    logic              claim_q;

    assign this_edge = slot_q + 1'b1;
    assign last_look = fast_all_i ? FAST_EDGE : SLOW_EDGE;

    // next-state logic
    always_comb begin
        state_d = state_q;
        slot_d  = slot_q;
        unique case (state_q)
            ST_IDLE: begin
                slot_d = SLOT_W'(1);
                if (!frame_n_i) begin
                    state_d = eligible_i ? ST_WAIT : ST_PASS;
                end
            end
            ST_WAIT: begin
                if (!devsel_n_i) begin
                    state_d = ST_PASS;
                end else if (this_edge == last_look) begin
                    state_d = ST_CLAIM;
                end else begin
                    slot_d = this_edge;
                end
            end
            ST_CLAIM: begin
                if (frame_n_i) state_d = ST_TURNOFF;
            end
            ST_TURNOFF: begin
                state_d = ST_IDLE;
            end
            ST_PASS: begin
                if (frame_n_i) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register, capture register and claim pulse
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= ST_IDLE;
            slot_q       <= '0;
            claim_q      <= 1'b0;
            claim_addr_o <= '0;
            claim_cmd_o  <= '0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            claim_q <= (state_q == ST_WAIT) && (state_d == ST_CLAIM);
            if (state_q == ST_IDLE && !frame_n_i) begin
                claim_addr_o <= ad_i;
                claim_cmd_o  <= cbe_n_i;
            end
        end
    end

    // outputs decoded from state
    always_comb begin
        devsel_oe_o = 1'b0;
        devsel_n_o  = 1'b1;
        unique case (state_q)
            ST_CLAIM: begin
                devsel_oe_o = 1'b1;
                devsel_n_o  = 1'b0;
            end
            ST_TURNOFF: begin
                devsel_oe_o = 1'b1;
                devsel_n_o  = 1'b1;
            end
            default: begin
                devsel_oe_o = 1'b0;
                devsel_n_o  = 1'b1;
            end
        endcase
    end
    assign claim_o = claim_q;

    // assertions
    assert_claim_drives_R5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> (devsel_oe_o && !devsel_n_o));

    assert_claim_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |=> !claim_o);

    assert_cancel_on_other_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !devsel_n_i) |=> (!claim_o && !devsel_oe_o));

    assert_never_odd_cmd_R4: assert property (@(posedge clk) disable iff (!rst_n)
        claim_o |-> (is_mem_cmd(claim_cmd_o) || is_io_cmd(claim_cmd_o)));

    assert_turnoff_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe_o && !devsel_n_o && frame_n_i) |=> (devsel_oe_o && devsel_n_o));

    assert_release_after_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (devsel_oe_o && devsel_n_o) |=> !devsel_oe_o);

endmodule

// File: rtl/subtractive_responder.sv
module subtractive_responder #(
    parameter int ADDR_W    = 32,
    parameter int MEM_AW    = 24,
    parameter int IO_AW     = 16,
    parameter int FAST_LAST = 3,
    parameter int SLOW_LAST = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_all_i,
    input  logic              frame_n_i,
    input  logic [ADDR_W-1:0] ad_i,
    input  logic [3:0]        cbe_n_i,
    input  logic              devsel_n_i,
    output logic              devsel_n_o,
    output logic              devsel_oe_o,
    output logic              claim_o,
    output logic [ADDR_W-1:0] claim_addr_o,
    output logic [3:0]        claim_cmd_o
);

    localparam int SLOT_W = $clog2(SLOW_LAST + 2);

    logic eligible;

    sdr_range_filter #(
        .ADDR_W (ADDR_W),
        .MEM_AW (MEM_AW),
        .IO_AW  (IO_AW)
    ) u_filter (
        .addr_i     (ad_i),
        .cmd_i      (cbe_n_i),
        .eligible_o (eligible)
    );

    sdr_claim_fsm #(
        .ADDR_W    (ADDR_W),
        .SLOT_W    (SLOT_W),
        .FAST_LAST (FAST_LAST),
        .SLOW_LAST (SLOW_LAST)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .fast_all_i   (fast_all_i),
        .frame_n_i    (frame_n_i),
        .ad_i         (ad_i),
        .cbe_n_i      (cbe_n_i),
        .devsel_n_i   (devsel_n_i),
        .eligible_i   (eligible),
        .devsel_n_o   (devsel_n_o),
        .devsel_oe_o  (devsel_oe_o),
        .claim_o      (claim_o),
        .claim_addr_o (claim_addr_o),
        .claim_cmd_o  (claim_cmd_o)
    );

endmodule

// File: tb/subtractive_responder_bench.sv
module subtractive_responder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_all = 1'b0;
    logic        frame_n = 1'b1;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = '0;
    logic        devsel_in_n = 1'b1;
    logic        devsel_n_o;
    logic        devsel_oe_o;
    logic        claim_o;
    logic [31:0] claim_addr_o;
    logic [3:0]  claim_cmd_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    subtractive_responder u_subtractive_responder (
        .clk          (clk),
        .rst_n        (rst_n),
        .fast_all_i   (fast_all),
        .frame_n_i    (frame_n),
        .ad_i         (ad),
        .cbe_n_i      (cbe_n),
        .devsel_n_i   (devsel_in_n),
        .devsel_n_o   (devsel_n_o),
        .devsel_oe_o  (devsel_oe_o),
        .claim_o      (claim_o),
        .claim_addr_o (claim_addr_o),
        .claim_cmd_o  (claim_cmd_o)
    );

    function automatic bit mem_code(input logic [3:0] c);
        return c == 4'b0110 || c == 4'b0111 || c == 4'b1100 ||
               c == 4'b1110 || c == 4'b1111;
    endfunction

    function automatic bit io_code(input logic [3:0] c);
        return c == 4'b0010 || c == 4'b0011;
    endfunction

    task automatic check3(input string tag, input bit oe, input bit dn, input bit cl);
        checks++;
        if (devsel_oe_o !== oe || devsel_n_o !== dn || claim_o !== cl) begin
            errors++;
            $display("FAIL %s: oe/devsel_n/claim got %b%b%b expected %b%b%b",
                     tag, devsel_oe_o, devsel_n_o, claim_o, oe, dn, cl);
        end
    endtask

    // other = clock at which another agent first drives DEVSEL#, 0 = none
    task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr,
                           input bit fast, input int other);
        bit    elig;
        bit    claims;
        int    pre;
        string tag;
        elig   = (mem_code(cmd) && addr[31:24] == 8'h00) ||
                 (io_code(cmd) && addr[31:16] == 16'h0000);
        pre    = fast ? 3 : 4;
        claims = elig && (other == 0 || other > pre);
        if (claims)            tag = fast ? "R6" : "R5";
        else if (elig)         tag = "R7";
        else if (mem_code(cmd)) tag = "R2/R8";
        else if (io_code(cmd))  tag = "R3/R8";
        else                    tag = "R4/R8";

        frame_n = 1'b1;
        devsel_in_n = 1'b1;
        @(posedge clk); #1;
        fast_all = fast;
        frame_n  = 1'b0;
        ad       = addr;
        cbe_n    = cmd;
        for (int e = 1; e <= 7; e++) begin
            @(posedge clk); #1;
            if (claims) begin
                if (e == pre) begin
                    check3(tag, 1'b1, 1'b0, 1'b1);
                    checks++;
                    if (claim_addr_o !== addr || claim_cmd_o !== cmd) begin
                        errors++;
                        $display("FAIL R1: addr/cmd got %h/%h expected %h/%h",
                                 claim_addr_o, claim_cmd_o, addr, cmd);
                    end
                end else if (e > pre && e <= 5) check3(tag, 1'b1, 1'b0, 1'b0);
                else if (e == 6) check3("R9", 1'b1, 1'b1, 1'b0);
                else if (e == 7) check3("R9", 1'b0, 1'b1, 1'b0);
                else check3(tag, 1'b0, 1'b1, 1'b0);
            end else begin
                check3(tag, 1'b0, 1'b1, 1'b0);
            end
            ad          = 32'hA5A5_5A5A;
            cbe_n       = 4'h0;
            frame_n     = (e + 1 >= 6);
            devsel_in_n = !(other != 0 && e + 1 >= other && e + 1 < 6);
        end
    endtask

    initial begin
        logic [31:0] addrs [6];
        addrs[0] = 32'h0000_1234;
        addrs[1] = 32'h0000_FFFF;
        addrs[2] = 32'h0001_0000;
        addrs[3] = 32'h00FF_FFFF;
        addrs[4] = 32'h0100_0000;
        addrs[5] = 32'hFFFF_FFFF;

        // R10: reset state
        #1;
        check3("R10", 1'b0, 1'b1, 1'b0);
        repeat (3) @(posedge clk);
        #1;
        check3("R10", 1'b0, 1'b1, 1'b0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check3("R10", 1'b0, 1'b1, 1'b0);

        for (int c = 0; c < 16; c++) begin
            for (int a = 0; a < 6; a++) begin
                for (int f = 0; f < 2; f++) begin
                    for (int o = 0; o <= 4; o++) begin
                        if (o == 1) continue;
                        if (f == 1 && o == 4) continue;
                        run_txn(4'(c), addrs[a], f[0], o);
                    end
                end
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: run did not finish, got timeout expected completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule